// File: doc/BRIEF.md
# Instruction Operand Fetcher and Effective Address Unit

This block sits at the front of an 8-bit CPU that has a 16-bit address space. When it is started with a program counter value, it reads one instruction a byte at a time through a request/valid port. An optional page-select byte may come first; if so, the opcode page is recorded. The opcode is then latched and shown to an external opcode table. That table returns the addressing mode and, for immediate forms, whether the operand is one byte or two. The block then fetches the operand bytes the mode calls for.

Once the last byte has arrived, the block forms either the immediate operand or the 16-bit effective address. It does this using the byte fields, the opcode location and the X or Y index register values supplied at its inputs. It then registers the result together with the instruction length and the page. A one-cycle done pulse marks the result, which stays unchanged until the block is started again. The caller gives the X and Y values and holds them steady until done.

Page-select byte values are parameters. Their defaults are 0x18 (page code 1), 0x1A (page code 2) and 0xCD (page code 3). The absence of such a byte gives page code 0.

Top module: `ofa_top`

## Requirements
- R1: After a synchronous reset, done_o, busy_o, fetch_req_o and illegal_o are all 0.
- R2: A start while idle begins fetching at pc_i. Each byte accepted (fetch_req_o and fetch_valid_i both high at a clock edge) advances fetch_addr_o by one, modulo 2^16. A start while busy is ignored and does not disturb the fetch sequence or the result.
- R3: Only the first byte of an instruction is tested against the page-select values. A match sets page_o to its page code (0x18 gives 1, 0x1A gives 2, 0xCD gives 3) and adds one to len_o. Operand bytes equal to a page-select value are treated as plain data.
- R4: Direct mode (tbl_mode_i = 2) fetches one byte. ea_o is 0x00 in the high byte and that byte in the low byte. len_o is 2, plus one after a page byte.
- R5: Extended mode (tbl_mode_i = 3) fetches two bytes, high byte first, and they form ea_o. len_o is 3, plus one after a page byte.
- R6: Indexed modes (tbl_mode_i = 4 for X, 5 for Y) fetch one unsigned offset byte. ea_o is the index value plus the zero-extended offset, modulo 2^16. len_o is 2, plus one after a page byte.
- R7: Immediate mode (tbl_mode_i = 1) fetches one byte when tbl_wide_i is 0 and two bytes (high first) when it is 1. The bytes appear zero-extended on operand_o. ea_o is the opcode address plus one, modulo 2^16. len_o is 2 or 3, plus one after a page byte.
- R8: Inherent mode (tbl_mode_i = 0) fetches no operand. ea_o and operand_o are 0, and len_o is 1, plus one after a page byte.
- R9: done_o is high for exactly one cycle per instruction. From that cycle until the next accepted start, ea_o, operand_o and len_o hold their values and fetch_req_o stays low.
- R10: A page-select byte followed by another page-select value ends the instruction at once. illegal_o is set, len_o is 2 and mode_o is 0. Table codes 6 and 7 also end the instruction with illegal_o set and len_o counting only the bytes fetched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new instruction at pc_i (only while idle) |
| pc_i | input | 16 | Address of the first instruction byte |
| idx_x_i | input | 16 | Current X index register value |
| idx_y_i | input | 16 | Current Y index register value |
| fetch_req_o | output | 1 | Byte read request |
| fetch_addr_o | output | 16 | Address of the byte requested |
| fetch_valid_i | input | 1 | Requested byte is on fetch_data_i |
| fetch_data_i | input | 8 | Fetched byte |
| dec_page_o | output | 2 | Page code shown to the opcode table |
| dec_opcode_o | output | 8 | Opcode shown to the opcode table |
| tbl_mode_i | input | 3 | Addressing mode from the table |
| tbl_wide_i | input | 1 | Immediate operand is two bytes |
| done_o | output | 1 | One-cycle result strobe |
| busy_o | output | 1 | Instruction in progress |
| illegal_o | output | 1 | Illegal page byte pair or reserved mode |
| mode_o | output | 3 | Addressing mode of the result |
| page_o | output | 2 | Page code of the result |
| opcode_o | output | 8 | Opcode of the result |
| ea_o | output | 16 | Effective address |
| operand_o | output | 16 | Immediate operand, zero-extended |
| len_o | output | 3 | Instruction length in bytes |

## Verification
Instructions are run in every addressing mode, with and without each page value. Each mode has its own expected address, so a mix-up between direct, extended, indexed and immediate handling shows up as a wrong ea_o or len_o. Index sums that cross 0xFFFF, and an immediate opcode placed at 0xFFFF, separate true 16-bit wrap from truncation or carry faults. An extended operand containing a page-select value, a back-to-back page byte pair and a reserved table code probe prebyte recognition. A stalled fetch with a stray start in the middle shows whether start is ignored while busy, and the fetch address is compared on every accepted byte.

// File: rtl/ofa_pkg.sv
package ofa_pkg;

  typedef enum logic [2:0] {
    AM_INH  = 3'd0,
    AM_IMM  = 3'd1,
    AM_DIR  = 3'd2,
    AM_EXT  = 3'd3,
    AM_IDX  = 3'd4,
    AM_IDY  = 3'd5,
    AM_RSV6 = 3'd6,
    AM_RSV7 = 3'd7
  } amode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FIRST,
    S_SECOND,
    S_DEC,
    S_OPR1,
    S_OPR2
  } fstate_e;

endpackage

// File: rtl/ofa_seq.sv
module ofa_seq
  import ofa_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 3,
  parameter logic [DATA_W-1:0] PRE_P1 = 8'h18,
  parameter logic [DATA_W-1:0] PRE_P2 = 8'h1A,
  parameter logic [DATA_W-1:0] PRE_P3 = 8'hCD
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [2*DATA_W-1:0]   pc,
  output logic                  fetch_req,
  output logic [2*DATA_W-1:0]   fetch_addr,
  input  logic                  fetch_valid,
  input  logic [DATA_W-1:0]     fetch_data,
  input  logic [2:0]            tbl_mode,
  input  logic                  tbl_wide,
  output logic                  busy,
  output logic                  fin,
  output logic                  ill,
  output amode_e                mode,
  output logic                  wide,
  output logic [1:0]            page,
  output logic [DATA_W-1:0]     opc,
  output logic [2*DATA_W-1:0]   opc_addr,
  output logic [DATA_W-1:0]     b1,
  output logic [DATA_W-1:0]     b2,
  output logic [LEN_W-1:0]      cnt
);

  localparam int ADDR_W = 2 * DATA_W;

  fstate_e             state;
  logic [ADDR_W-1:0]   addr_q;
  logic                two_q;
  logic                accept;
  logic [1:0]          pg_in;

  function automatic logic [1:0] page_of(input logic [DATA_W-1:0] b);
    if (b == PRE_P1)      return 2'd1;
    else if (b == PRE_P2) return 2'd2;
    else if (b == PRE_P3) return 2'd3;
    else                  return 2'd0;
  endfunction

  assign fetch_req  = (state == S_FIRST) || (state == S_SECOND) ||
                      (state == S_OPR1)  || (state == S_OPR2);
  assign accept     = fetch_req && fetch_valid;
  assign fetch_addr = addr_q;
  assign pg_in      = page_of(fetch_data);
  assign busy       = (state != S_IDLE) || fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      cnt      <= '0;
      page     <= '0;
      opc      <= '0;
      opc_addr <= '0;
      b1       <= '0;
      b2       <= '0;
      mode     <= AM_INH;
      wide     <= 1'b0;
      two_q    <= 1'b0;
      fin      <= 1'b0;
      ill      <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (accept) begin
        addr_q <= addr_q + ADDR_W'(1);
        cnt    <= cnt + LEN_W'(1);
      end
      unique case (state)
        S_IDLE: begin
          if (start && !fin) begin
            addr_q <= pc;
            cnt    <= '0;
            page   <= '0;
            b1     <= '0;
            b2     <= '0;
            ill    <= 1'b0;
            mode   <= AM_INH;
            wide   <= 1'b0;
            state  <= S_FIRST;
          end
        end
        S_FIRST: begin
          if (accept) begin
            if (pg_in != 2'd0) begin
              page  <= pg_in;
              state <= S_SECOND;
            end else begin
              opc      <= fetch_data;
              opc_addr <= addr_q;
              state    <= S_DEC;
            end
          end
        end
        S_SECOND: begin
          if (accept) begin
            opc <= fetch_data;
            if (pg_in != 2'd0) begin
              ill   <= 1'b1;
              fin   <= 1'b1;
              state <= S_IDLE;
            end else begin
              opc_addr <= addr_q;
              state    <= S_DEC;
            end
          end
        end
        S_DEC: begin
          mode <= amode_e'(tbl_mode);
          wide <= tbl_wide;
          unique case (amode_e'(tbl_mode))
            AM_INH: begin
              fin   <= 1'b1;
              state <= S_IDLE;
            end
            AM_IMM: begin
              two_q <= tbl_wide;
              state <= S_OPR1;
            end
            AM_EXT: begin
              two_q <= 1'b1;
              state <= S_OPR1;
            end
            AM_DIR, AM_IDX, AM_IDY: begin
              two_q <= 1'b0;
              state <= S_OPR1;
            end
            default: begin
              ill   <= 1'b1;
              fin   <= 1'b1;
              state <= S_IDLE;
            end
          endcase
        end
        S_OPR1: begin
          if (accept) begin
            b1 <= fetch_data;
            if (two_q) begin
              state <= S_OPR2;
            end else begin
              fin   <= 1'b1;
              state <= S_IDLE;
            end
          end
        end
        S_OPR2: begin
          if (accept) begin
            b2    <= fetch_data;
            fin   <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: every accepted byte moves the fetch pointer forward by exactly one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    accept |=> (fetch_addr == $past(fetch_addr) + ADDR_W'(1)));

  // R3: a page code is only ever recorded from the byte before the opcode
  a_r3_page_once: assert property (@(posedge clk) disable iff (rst)
    (state == S_OPR1 || state == S_OPR2) |=> $stable(page));

endmodule

// File: rtl/ofa_agen.sv
module ofa_agen
  import ofa_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  amode_e                mode,
  input  logic                  wide,
  input  logic [DATA_W-1:0]     b1,
  input  logic [DATA_W-1:0]     b2,
  input  logic [2*DATA_W-1:0]   opc_addr,
  input  logic [2*DATA_W-1:0]   idx_x,
  input  logic [2*DATA_W-1:0]   idx_y,
  output logic [2*DATA_W-1:0]   ea,
  output logic [2*DATA_W-1:0]   operand
);

  localparam int ADDR_W = 2 * DATA_W;

  logic [ADDR_W-1:0] off_ext;
  assign off_ext = {{(ADDR_W-DATA_W){1'b0}}, b1};

  always_comb begin
    ea      = '0;
    operand = '0;
    unique case (mode)
      AM_IMM: begin
        ea      = opc_addr + ADDR_W'(1);
        operand = wide ? {b1, b2} : off_ext;
      end
      AM_DIR:  ea = off_ext;
      AM_EXT:  ea = {b1, b2};
      AM_IDX:  ea = idx_x + off_ext;
      AM_IDY:  ea = idx_y + off_ext;
      default: ea = '0;
    endcase
  end

endmodule

// File: rtl/ofa_top.sv
module ofa_top
  import ofa_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] PRE_P1 = 8'h18,
  parameter logic [DATA_W-1:0] PRE_P2 = 8'h1A,
  parameter logic [DATA_W-1:0] PRE_P3 = 8'hCD
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [2*DATA_W-1:0]  pc_i,
  input  logic [2*DATA_W-1:0]  idx_x_i,
  input  logic [2*DATA_W-1:0]  idx_y_i,
  output logic                 fetch_req_o,
  output logic [2*DATA_W-1:0]  fetch_addr_o,
  input  logic                 fetch_valid_i,
  input  logic [DATA_W-1:0]    fetch_data_i,
  output logic [1:0]           dec_page_o,
  output logic [DATA_W-1:0]    dec_opcode_o,
  input  logic [2:0]           tbl_mode_i,
  input  logic                 tbl_wide_i,
  output logic                 done_o,
  output logic                 busy_o,
  output logic                 illegal_o,
  output logic [2:0]           mode_o,
  output logic [1:0]           page_o,
  output logic [DATA_W-1:0]    opcode_o,
  output logic [2*DATA_W-1:0]  ea_o,
  output logic [2*DATA_W-1:0]  operand_o,
  output logic [2:0]           len_o
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam int LEN_W  = 3;

  logic               fin, ill, wide;
  amode_e             mode;
  logic [1:0]         page;
  logic [DATA_W-1:0]  opc, b1, b2;
  logic [ADDR_W-1:0]  opc_addr, ea_c, opnd_c;
  logic [LEN_W-1:0]   cnt;

  ofa_seq #(
    .DATA_W(DATA_W), .LEN_W(LEN_W),
    .PRE_P1(PRE_P1), .PRE_P2(PRE_P2), .PRE_P3(PRE_P3)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .pc(pc_i),
    .fetch_req(fetch_req_o), .fetch_addr(fetch_addr_o),
    .fetch_valid(fetch_valid_i), .fetch_data(fetch_data_i),
    .tbl_mode(tbl_mode_i), .tbl_wide(tbl_wide_i),
    .busy(busy_o), .fin(fin), .ill(ill), .mode(mode), .wide(wide),
    .page(page), .opc(opc), .opc_addr(opc_addr),
    .b1(b1), .b2(b2), .cnt(cnt)
  );

  ofa_agen #(.DATA_W(DATA_W)) u_agen (
    .mode(mode), .wide(wide), .b1(b1), .b2(b2), .opc_addr(opc_addr),
    .idx_x(idx_x_i), .idx_y(idx_y_i), .ea(ea_c), .operand(opnd_c)
  );

  assign dec_page_o   = page;
  assign dec_opcode_o = opc;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      mode_o    <= '0;
      page_o    <= '0;
      opcode_o  <= '0;
      ea_o      <= '0;
      operand_o <= '0;
      len_o     <= '0;
    end else begin
      done_o <= fin;
      if (fin) begin
        illegal_o <= ill;
        mode_o    <= mode;
        page_o    <= page;
        opcode_o  <= opc;
        ea_o      <= ea_c;
        operand_o <= opnd_c;
        len_o     <= cnt;
      end
    end
  end

  // R9: the result strobe never lasts two cycles
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9: results hold while idle and not restarted
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start) |=> ($stable(ea_o) && $stable(len_o) && $stable(operand_o)));

  // R4: direct results stay in the first 256 bytes
  a_r4_direct_page: assert property (@(posedge clk) disable iff (rst)
    (done_o && !illegal_o && mode_o == AM_DIR) |-> (ea_o[ADDR_W-1:DATA_W] == '0));

  // R5: extended length is three, or four after a page byte
  a_r5_ext_len: assert property (@(posedge clk) disable iff (rst)
    (done_o && !illegal_o && mode_o == AM_EXT) |-> (len_o == ((page_o != 2'd0) ? 3'd4 : 3'd3)));

  // R8: inherent length is one, or two after a page byte
  a_r8_inh_len: assert property (@(posedge clk) disable iff (rst)
    (done_o && !illegal_o && mode_o == AM_INH) |-> (len_o == ((page_o != 2'd0) ? 3'd2 : 3'd1)));

  // R10: an illegal result leaves no fetch outstanding
  a_r10_no_req: assert property (@(posedge clk) disable iff (rst)
    (done_o && illegal_o) |-> !fetch_req_o);

endmodule

// File: tb/ofa_top_tb.sv
`timescale 1ns/1ps
module ofa_top_tb;

  typedef struct packed {
    logic [15:0] ea;
    logic [15:0] opnd;
    logic [2:0]  len;
    logic [2:0]  mode;
    logic [1:0]  page;
    logic [7:0]  opc;
    logic        ill;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] pc_i = '0, idx_x_i = '0, idx_y_i = '0;
  logic        fetch_req_o, fetch_valid_i = 1'b0;
  logic [15:0] fetch_addr_o;
  logic [7:0]  fetch_data_i = '0;
  logic [1:0]  dec_page_o;
  logic [7:0]  dec_opcode_o;
  logic [2:0]  tbl_mode_i;
  logic        tbl_wide_i;
  logic        done_o, busy_o, illegal_o;
  logic [2:0]  mode_o, len_o;
  logic [1:0]  page_o;
  logic [7:0]  opcode_o;
  logic [15:0] ea_o, operand_o;

  always #2.5 clk = ~clk;

  ofa_top u_dut (
    .clk(clk), .rst(rst), .start(start), .pc_i(pc_i),
    .idx_x_i(idx_x_i), .idx_y_i(idx_y_i),
    .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
    .fetch_valid_i(fetch_valid_i), .fetch_data_i(fetch_data_i),
    .dec_page_o(dec_page_o), .dec_opcode_o(dec_opcode_o),
    .tbl_mode_i(tbl_mode_i), .tbl_wide_i(tbl_wide_i),
    .done_o(done_o), .busy_o(busy_o), .illegal_o(illegal_o),
    .mode_o(mode_o), .page_o(page_o), .opcode_o(opcode_o),
    .ea_o(ea_o), .operand_o(operand_o), .len_o(len_o)
  );

  // Bench opcode table: mode in opcode bits 2:0, wide flag in bit 3
  assign tbl_mode_i = dec_opcode_o[2:0];
  assign tbl_wide_i = dec_opcode_o[3];

  logic [7:0]  mem [0:255];
  logic [15:0] exp_addr = '0;
  exp_t        sb_q[$];
  int          n_chk = 0, n_err = 0, n_done = 0, phase = 0, cyc = 0;
  bit          stall_en = 1'b0;
  bit          finished = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // memory responder with R2 address check on each accepted byte
  always @(negedge clk) begin
    fetch_valid_i = 1'b0;
    if (!rst && fetch_req_o) begin
      phase++;
      if (!stall_en || (phase % 3 == 0)) begin
        fetch_valid_i = 1'b1;
        fetch_data_i  = mem[fetch_addr_o[7:0]];
        chk("R2", "fetch address", {16'h0, fetch_addr_o}, {16'h0, exp_addr});
        exp_addr = exp_addr + 16'd1;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (sb_q.size() == 0) begin
        chk("R9", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R4-7", "ea", {16'h0, ea_o}, {16'h0, e.ea});
        chk("R7", "operand", {16'h0, operand_o}, {16'h0, e.opnd});
        chk("R3", "length", {29'h0, len_o}, {29'h0, e.len});
        chk("R3", "page", {30'h0, page_o}, {30'h0, e.page});
        chk("R6", "mode", {29'h0, mode_o}, {29'h0, e.mode});
        chk("R10", "illegal", {31'h0, illegal_o}, {31'h0, e.ill});
        chk("R3", "opcode", {24'h0, opcode_o}, {24'h0, e.opc});
      end
      n_done++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic run(input logic [15:0] pc, input logic [15:0] x,
                     input logic [15:0] y, input exp_t e, input bit poke);
    int k;
    logic [15:0] ea_snap;
    k = n_done;
    sb_q.push_back(e);
    exp_addr = pc;
    idx_x_i  = x;
    idx_y_i  = y;
    @(negedge clk);
    start = 1'b1;
    pc_i  = pc;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      start = 1'b1;
      pc_i  = pc + 16'h0040;
      @(negedge clk);
      start = 1'b0;
    end
    wait (n_done == k + 1);
    @(negedge clk);
    chk("R9", "done width", {31'h0, done_o}, 32'd0);
    ea_snap = ea_o;
    repeat (2) @(negedge clk);
    chk("R9", "ea held", {16'h0, ea_o}, {16'h0, ea_snap});
    chk("R9", "idle no request", {31'h0, fetch_req_o}, 32'd0);
  endtask

  function automatic exp_t mk(input logic [15:0] ea, input logic [15:0] op,
                              input logic [2:0] len, input logic [2:0] mode,
                              input logic [1:0] page, input logic [7:0] opc,
                              input logic ill);
    exp_t e;
    e.ea = ea; e.opnd = op; e.len = len; e.mode = mode;
    e.page = page; e.opc = opc; e.ill = ill;
    return e;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    // programs (low address byte only; high byte is don't care to memory)
    mem[8'h10] = 8'h40;                                     // inherent
    mem[8'h20] = 8'h81; mem[8'h21] = 8'h24;                 // imm8
    mem[8'h30] = 8'h89; mem[8'h31] = 8'h12; mem[8'h32] = 8'h34; // imm16
    mem[8'h40] = 8'h92; mem[8'h41] = 8'h7F;                 // direct
    mem[8'h50] = 8'hB3; mem[8'h51] = 8'h12; mem[8'h52] = 8'h34; // extended
    mem[8'h60] = 8'hE4; mem[8'h61] = 8'hFF;                 // idx X
    mem[8'h70] = 8'hE4; mem[8'h71] = 8'h20;                 // idx X wrap
    mem[8'h80] = 8'h18; mem[8'h81] = 8'hE5; mem[8'h82] = 8'h04; // page1 idx Y
    mem[8'h90] = 8'h1A; mem[8'h91] = 8'h92; mem[8'h92] = 8'h33; // page2 direct
    mem[8'hA0] = 8'hCD; mem[8'hA1] = 8'hB3; mem[8'hA2] = 8'hAB; mem[8'hA3] = 8'hCD;
    mem[8'hB0] = 8'h18; mem[8'hB1] = 8'h1A;                 // double prebyte
    mem[8'hC0] = 8'h06;                                     // reserved mode
    mem[8'hD0] = 8'h18; mem[8'hD1] = 8'h40;                 // page1 inherent
    mem[8'hFF] = 8'h81; mem[8'h00] = 8'h5A;                 // imm at 0xFFFF

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "done", {31'h0, done_o}, 32'd0);
    chk("R1", "busy", {31'h0, busy_o}, 32'd0);
    chk("R1", "fetch_req", {31'h0, fetch_req_o}, 32'd0);
    chk("R1", "illegal", {31'h0, illegal_o}, 32'd0);

    // R8 inherent
    run(16'hC010, 16'h0, 16'h0, mk(16'h0000, 16'h0, 3'd1, 3'd0, 2'd0, 8'h40, 1'b0), 1'b0);
    // R7 immediate one and two bytes
    run(16'hC020, 16'h0, 16'h0, mk(16'hC021, 16'h0024, 3'd2, 3'd1, 2'd0, 8'h81, 1'b0), 1'b0);
    run(16'hC030, 16'h0, 16'h0, mk(16'hC031, 16'h1234, 3'd3, 3'd1, 2'd0, 8'h89, 1'b0), 1'b0);
    // R4 direct
    run(16'hC040, 16'h0, 16'h0, mk(16'h007F, 16'h0, 3'd2, 3'd2, 2'd0, 8'h92, 1'b0), 1'b0);
    // R5 extended
    run(16'hC050, 16'h0, 16'h0, mk(16'h1234, 16'h0, 3'd3, 3'd3, 2'd0, 8'hB3, 1'b0), 1'b0);
    // R6 indexed X, max offset and wrap past 0xFFFF
    run(16'hC060, 16'h1000, 16'h5555, mk(16'h10FF, 16'h0, 3'd2, 3'd4, 2'd0, 8'hE4, 1'b0), 1'b0);
    run(16'hC070, 16'hFFF0, 16'h0, mk(16'h0010, 16'h0, 3'd2, 3'd4, 2'd0, 8'hE4, 1'b0), 1'b0);
    // R3 page prebytes: indexed Y, direct, extended with stall and stray start (R2)
    run(16'hC080, 16'h7777, 16'h2000, mk(16'h2004, 16'h0, 3'd3, 3'd5, 2'd1, 8'hE5, 1'b0), 1'b0);
    run(16'hC090, 16'h0, 16'h0, mk(16'h0033, 16'h0, 3'd3, 3'd2, 2'd2, 8'h92, 1'b0), 1'b0);
    stall_en = 1'b1;
    run(16'hC0A0, 16'h0, 16'h0, mk(16'hABCD, 16'h0, 3'd4, 3'd3, 2'd3, 8'hB3, 1'b0), 1'b1);
    stall_en = 1'b0;
    // R10 double prebyte and reserved mode
    run(16'hC0B0, 16'h0, 16'h0, mk(16'h0000, 16'h0, 3'd2, 3'd0, 2'd1, 8'h1A, 1'b1), 1'b0);
    run(16'hC0C0, 16'h0, 16'h0, mk(16'h0000, 16'h0, 3'd1, 3'd6, 2'd0, 8'h06, 1'b1), 1'b0);
    // R8 inherent after page byte
    run(16'hC0D0, 16'h0, 16'h0, mk(16'h0000, 16'h0, 3'd2, 3'd0, 2'd1, 8'h40, 1'b0), 1'b0);
    // R7 immediate opcode at top of memory: ea wraps to 0
    run(16'hFFFF, 16'h0, 16'h0, mk(16'h0000, 16'h005A, 3'd2, 3'd1, 2'd0, 8'h81, 1'b0), 1'b0);

    chk("R9", "scoreboard drained", sb_q.size(), 32'd0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule